// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked on-chip request bus and an external asynchronous static RAM with a 16-bit data path. It accepts one read or write at a time through a valid/ready handshake. Each request becomes a sequence of registered strobes on the RAM pins: an active-low and an active-high chip select, an output enable, a write enable and one enable per byte lane. Every asynchronous timing limit is a parameter in nanoseconds. Each one is turned into a whole number of clock cycles by ceiling division by the clock period, with a floor of one cycle.

A write selects the device and drives the data for one setup cycle. It then holds write enable low for the pulse width, which also covers the data-valid-before-end window. A recovery phase follows so that the whole write cycle is long enough. A read selects the device with output enable low and captures the pins once both the address access time and the output-enable access time have elapsed. It then releases every strobe and waits out the float time before it accepts another request, so the controller's own drivers never fight the RAM. A request with both byte strobes clear is accepted and dropped without touching any pin.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after reset, every strobe is inactive: low-active select high, high-active select low, write enable, output enable and both lane enables high. The data drivers are off and `req_ready` is high.
- R2: Write enable is low only while both selects are active, at least one lane enable is low and the data drivers are on. Output enable stays high for the whole write.
- R3: `req_be[0]` drives the lower lane enable, which governs data bits 7:0. `req_be[1]` drives the upper lane enable, which governs bits 15:8. A write leaves the memory byte of a lane that is not enabled unchanged.
- R4: A read holds output enable low, write enable high and the data drivers off. The lane enables follow `req_be`. Only the requested lanes of `rd_data` are defined.
- R5: A request with `req_be == 2'b00` is accepted in one cycle and pulses no strobe. `req_ready` stays high, no `rd_valid` follows, and memory is unchanged.
- R6: A write spends one cycle with the selects active and write enable high. It then spends P = max(ceil(tWP), ceil(tDW)) cycles with write enable low (5 at defaults), then max(1, ceil(tWC) − 1 − P) recovery cycles. Address and write data do not change while write enable is low.
- R7: `rd_valid` and `rd_data` appear A = max(ceil(tAA), ceil(tOE)) cycles after the accepting edge (7 at defaults). The data is sampled from the pins on the last access cycle.
- R8: `rd_valid` is a one-cycle pulse. `rd_data` holds its value until the next read completes.
- R9: After a read, all strobes are released and `req_ready` stays low for T = max(ceil(tOHZ), ceil(tHZ)) further cycles (3 at defaults). The data drivers turn on no earlier than the cycle after that wait.
- R10: `req_ready` is low from the accepting edge until the sequence ends: 7 cycles for a write and 10 for a read at defaults. The RAM address equals the accepted address throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Byte strobes, bit 0 lower lane, bit 1 upper lane |
| rd_data | output | DATA_W | Captured read data |
| rd_valid | output | 1 | One-cycle read completion pulse |
| sram_addr | output | ADDR_W | RAM address pins |
| sram_ce_n | output | 1 | Active-low chip select |
| sram_ce | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Lower lane enable, active low |
| sram_ub_n | output | 1 | Upper lane enable, active low |
| sram_dq_out | output | DATA_W | Data driven toward the RAM |
| sram_dq_in | input | DATA_W | Data received from the RAM |
| sram_dq_oe | output | 1 | Data driver enable |

## Verification
The assertions assume that the bus side only offers requests and that the address, data, write flag and byte strobes are stable on the edge where `req_valid` and `req_ready` are both high. The no-op assertion also assumes `req_be` is a clean two-bit value on that edge. The directed tasks change inputs only on falling edges and release `req_valid` just after acceptance. The single exception is the back-to-back case, which holds a write request valid across a busy read on purpose. A behavioural RAM model in the bench returns junk until the access count has elapsed. It counts pulse-width, address-stability, contention and turnaround violations, so early sampling or short waits show up at the ports.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOV,
    ST_RD_ACCESS,
    ST_RD_TURN
  } seq_state_e;

  // nanoseconds to whole cycles, never below one
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (sample) data_q <= dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= sample;
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

  AST_RDVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R8
  AST_RDDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample) |-> $stable(data_q)); // R8

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int CNT_W        = 3,
  parameter int WR_PULSE_CYC = 5,
  parameter int WR_RECOV_CYC = 1,
  parameter int RD_ACC_CYC   = 7,
  parameter int RD_TURN_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_done,
  output logic              sample,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_ce,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe
);

  localparam logic [CNT_W-1:0] LD_SETUP = '0;
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(WR_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RECOV = CNT_W'(WR_RECOV_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(RD_ACC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(RD_TURN_CYC - 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              ce_n_q, ce_n_d;
  logic              ce_q, ce_d;
  logic              we_n_q, we_n_d;
  logic              oe_n_q, oe_n_d;
  logic              lb_n_q, lb_n_d;
  logic              ub_n_q, ub_n_d;
  logic              dq_oe_q, dq_oe_d;
  logic              accept;
  logic              cap_en;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid && (req_be != 2'b00);
  assign cap_en    = accept;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    ce_n_d   = ce_n_q;
    ce_d     = ce_q;
    we_n_d   = we_n_q;
    oe_n_d   = oe_n_q;
    lb_n_d   = lb_n_q;
    ub_n_d   = ub_n_q;
    dq_oe_d  = dq_oe_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    sample   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          addr_d   = req_addr;
          ce_n_d   = 1'b0;
          ce_d     = 1'b1;
          lb_n_d   = !req_be[0];
          ub_n_d   = !req_be[1];
          cnt_load = 1'b1;
          if (req_write) begin
            wdata_d = req_wdata;
            dq_oe_d = 1'b1;
            cnt_val = LD_SETUP;
            state_d = ST_WR_SETUP;
          end else begin
            oe_n_d  = 1'b0;
            cnt_val = LD_ACC;
            state_d = ST_RD_ACCESS;
          end
        end
      end
      ST_WR_SETUP: begin
        if (cnt_done) begin
          we_n_d   = 1'b0;
          cnt_load = 1'b1;
          cnt_val  = LD_PULSE;
          state_d  = ST_WR_PULSE;
        end
      end
      ST_WR_PULSE: begin
        if (cnt_done) begin
          we_n_d   = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = LD_RECOV;
          state_d  = ST_WR_RECOV;
        end
      end
      ST_WR_RECOV: begin
        if (cnt_done) begin
          ce_n_d  = 1'b1;
          ce_d    = 1'b0;
          lb_n_d  = 1'b1;
          ub_n_d  = 1'b1;
          dq_oe_d = 1'b0;
          state_d = ST_IDLE;
        end
      end
      ST_RD_ACCESS: begin
        if (cnt_done) begin
          sample   = 1'b1;
          ce_n_d   = 1'b1;
          ce_d     = 1'b0;
          oe_n_d   = 1'b1;
          lb_n_d   = 1'b1;
          ub_n_d   = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = LD_TURN;
          state_d  = ST_RD_TURN;
        end
      end
      ST_RD_TURN: begin
        if (cnt_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      ce_q    <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      lb_n_q  <= 1'b1;
      ub_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= ce_n_d;
      ce_q    <= ce_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      lb_n_q  <= lb_n_d;
      ub_n_q  <= ub_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign sram_addr   = addr_q;
  assign sram_ce_n   = ce_n_q;
  assign sram_ce     = ce_q;
  assign sram_we_n   = we_n_q;
  assign sram_oe_n   = oe_n_q;
  assign sram_lb_n   = lb_n_q;
  assign sram_ub_n   = ub_n_q;
  assign sram_dq_out = wdata_q;
  assign sram_dq_oe  = dq_oe_q;

  AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> (!ce_n_q && ce_q && (!lb_n_q || !ub_n_q) && dq_oe_q && oe_n_q)); // R2
  AST_ADDR_STABLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!we_n_q) |-> $stable(addr_q)); // R6
  AST_WDATA_STABLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!we_n_q) |-> $stable(wdata_q)); // R6
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> (we_n_q && !dq_oe_q)); // R4
  AST_NOOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_be == 2'b00)) |=>
      (req_ready && ce_n_q && !ce_q && we_n_q && oe_n_q)); // R5
  AST_IDLE_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n_q && we_n_q && oe_n_q && !dq_oe_q)); // R10
  AST_BUSY_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(addr_q)); // R10

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_WC_NS       = 70,
  parameter int T_WP_NS       = 50,
  parameter int T_DW_NS       = 30,
  parameter int T_AA_NS       = 70,
  parameter int T_OE_NS       = 40,
  parameter int T_OHZ_NS      = 25,
  parameter int T_HZ_NS       = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_ce,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);

  localparam int WR_PULSE_CYC = imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_DW_NS, CLK_PERIOD_NS));
  localparam int WR_RECOV_CYC = imax(1, ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - 1 - WR_PULSE_CYC);
  localparam int RD_ACC_CYC   = imax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
  localparam int RD_TURN_CYC  = imax(ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS));
  localparam int MAX_CYC      = imax(imax(WR_PULSE_CYC, WR_RECOV_CYC),
                                     imax(RD_ACC_CYC, RD_TURN_CYC));
  localparam int CNT_W        = $clog2(MAX_CYC + 1);

  // reset: asserted at once, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_done;
  logic             sample;

  sram_seq_fsm #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .CNT_W        (CNT_W),
    .WR_PULSE_CYC (WR_PULSE_CYC),
    .WR_RECOV_CYC (WR_RECOV_CYC),
    .RD_ACC_CYC   (RD_ACC_CYC),
    .RD_TURN_CYC  (RD_TURN_CYC)
  ) i_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_be      (req_be),
    .req_ready   (req_ready),
    .cnt_load    (cnt_load),
    .cnt_val     (cnt_val),
    .cnt_done    (cnt_done),
    .sample      (sample),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_ce     (sram_ce),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_lb_n   (sram_lb_n),
    .sram_ub_n   (sram_ub_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
  );

  sram_wait_cnt #(
    .CNT_W (CNT_W)
  ) i_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (cnt_load),
    .load_val (cnt_val),
    .done     (cnt_done)
  );

  sram_rd_capture #(
    .DATA_W (DATA_W)
  ) i_cap (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .sample   (sample),
    .dq_in    (sram_dq_in),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

  localparam int CLK_NS   = 10;
  localparam int P_CYC    = 5;           // ceil(50/10) vs ceil(30/10)
  localparam int WR_BUSY  = 1 + P_CYC + 1; // recovery max(1, 7-1-5)
  localparam int ACC      = 7;           // ceil(70/10) vs ceil(40/10)
  localparam int TURN     = 3;           // ceil(25/10) vs ceil(30/10)
  localparam int RD_BUSY  = ACC + TURN;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;
  logic [15:0] sram_dq_out, sram_dq_in;
  logic        sram_dq_oe;

  int total, failed;
  bit done_flag;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rd_data(rd_data), .rd_valid(rd_valid),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n),
    .sram_ub_n(sram_ub_n), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
    .sram_dq_oe(sram_dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  // ---------------- behavioural RAM model ----------------
  logic [15:0] mem [64];
  int acc_cnt, we_low_cnt, last_pulse, oe_hi_cnt, viol;
  logic        we_n_prev, dq_oe_prev;
  logic [17:0] addr_prev;
  wire sel = !sram_ce_n && sram_ce;
  wire rd_cond = sel && !sram_oe_n && sram_we_n;

  assign sram_dq_in = !rd_cond ? 16'h0000 :
                      (acc_cnt < ACC) ? 16'hA5A5 :
                      {sram_ub_n ? 8'h00 : mem[sram_addr[5:0]][15:8],
                       sram_lb_n ? 8'h00 : mem[sram_addr[5:0]][7:0]};

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    viol = 0; acc_cnt = 0; we_low_cnt = 0; last_pulse = 0; oe_hi_cnt = 1000;
    we_n_prev = 1'b1; dq_oe_prev = 1'b0; addr_prev = '0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_cond) acc_cnt = acc_cnt + 1; else acc_cnt = 0;
      if (!sram_we_n) begin
        if (!we_n_prev && sram_addr != addr_prev) viol = viol + 1;
        if (!sel || (sram_lb_n && sram_ub_n) || !sram_dq_oe) viol = viol + 1;
        we_low_cnt = we_low_cnt + 1;
      end else if (!we_n_prev) begin
        if (we_low_cnt < P_CYC) viol = viol + 1;
        last_pulse = we_low_cnt;
        we_low_cnt = 0;
        if (sel && sram_dq_oe) begin
          if (!sram_lb_n) mem[addr_prev[5:0]][7:0]  = sram_dq_out[7:0];
          if (!sram_ub_n) mem[addr_prev[5:0]][15:8] = sram_dq_out[15:8];
        end else viol = viol + 1;
      end
      if (sram_oe_n) begin if (oe_hi_cnt < 1000) oe_hi_cnt = oe_hi_cnt + 1; end
      else oe_hi_cnt = 0;
      if (sram_dq_oe && !dq_oe_prev && oe_hi_cnt <= TURN) viol = viol + 1;
      if (sram_dq_oe && rd_cond) viol = viol + 1;
      we_n_prev  = sram_we_n;
      dq_oe_prev = sram_dq_oe;
      addr_prev  = sram_addr;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  task automatic idle_strobes(input string tag);
    chk(sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n && !sram_dq_oe,
        tag, {sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe}, 7'b1011110);
  endtask

  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    idle_strobes("R1 strobes in reset");
    chk(req_ready && !rd_valid, "R1 ready in reset", {req_ready, rd_valid}, 2'b10);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_strobes("R1 strobes after reset");
    chk(req_ready, "R1 ready after reset", req_ready, 1);
  endtask

  task automatic t_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    int busy; bit addr_ok; bit oe_ok;
    busy = 0; addr_ok = 1; oe_ok = 1;
    issue(1'b1, a, d, be);
    for (int n = 0; n < 15; n++) begin
      if (!req_ready) begin
        busy++;
        if (sram_addr != a) addr_ok = 0;
      end
      if (!sram_oe_n) oe_ok = 0;
      @(negedge clk);
    end
    chk(busy == WR_BUSY, "R10 write busy cycles", busy, WR_BUSY);
    chk(addr_ok, "R10 address held during write", sram_addr, a);
    chk(oe_ok, "R2 output enable high during write", 0, 1);
    chk(last_pulse == P_CYC, "R6 write pulse width", last_pulse, P_CYC);
    idle_strobes("R1 strobes released after write");
  endtask

  task automatic t_read(input logic [17:0] a, input logic [1:0] be, input logic [15:0] exp);
    int busy; int vcnt; int vpos; logic [15:0] got; logic [15:0] mask; bit drv_ok; bit lane_ok;
    busy = 0; vcnt = 0; vpos = -1; got = '0; drv_ok = 1; lane_ok = 1;
    mask = {{8{be[1]}}, {8{be[0]}}};
    issue(1'b0, a, 16'h0, be);
    for (int n = 0; n < 20; n++) begin
      if (!req_ready) busy++;
      if (sram_dq_oe) drv_ok = 0;
      if (n < ACC && (sram_lb_n != !be[0] || sram_ub_n != !be[1] || sram_oe_n || !sram_we_n))
        lane_ok = 0;
      if (rd_valid) begin vcnt++; vpos = n; got = rd_data; end
      @(negedge clk);
    end
    chk((got & mask) == (exp & mask), "R7 read data", got & mask, exp & mask);
    chk(vpos == ACC, "R7 read valid latency", vpos, ACC);
    chk(vcnt == 1, "R8 read valid single pulse", vcnt, 1);
    chk(busy == RD_BUSY, "R9 read busy incl turnaround", busy, RD_BUSY);
    chk(drv_ok, "R4 drivers off during read", 1, 0);
    chk(lane_ok, "R3 R4 lane enables and strobes during read", 0, 1);
    chk(rd_data == got, "R8 read data held", rd_data, got);
  endtask

  task automatic t_noop(input bit wr, input logic [17:0] a);
    bit quiet; int vcnt;
    quiet = 1; vcnt = 0;
    issue(wr, a, 16'hFFFF, 2'b00);
    for (int n = 0; n < 10; n++) begin
      if (!req_ready || !sram_ce_n || sram_ce || !sram_we_n || !sram_oe_n || sram_dq_oe) quiet = 0;
      if (rd_valid) vcnt++;
      @(negedge clk);
    end
    chk(quiet, "R5 no-op leaves strobes and ready idle", 0, 1);
    chk(vcnt == 0, "R5 no-op gives no read valid", vcnt, 0);
  endtask

  task automatic t_back_to_back();
    int first_drv; int oe_rise;
    first_drv = -1; oe_rise = -1;
    issue(1'b0, 18'h2A522, 16'h0, 2'b11);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h01333; req_wdata = 16'h3333; req_be = 2'b11;
    for (int n = 0; n < 25; n++) begin
      if (sram_dq_oe && first_drv < 0) first_drv = n;
      if (sram_oe_n && oe_rise < 0) oe_rise = n;
      if (req_ready) begin
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n++;
        if (sram_dq_oe && first_drv < 0) first_drv = n;
      end else @(negedge clk);
    end
    chk(oe_rise == ACC, "R9 output enable released", oe_rise, ACC);
    chk(first_drv == RD_BUSY + 1, "R9 turnaround before driving", first_drv, RD_BUSY + 1);
  endtask

  // ---------------- main ----------------
  initial begin
    total = 0; failed = 0; done_flag = 1'b0;
    t_reset();
    t_write(18'h2A511, 16'h1234, 2'b11);
    t_read (18'h2A511, 2'b11, 16'h1234);
    t_write(18'h2A511, 16'hABCD, 2'b01);
    t_read (18'h2A511, 2'b11, 16'h12CD);          // R3 upper kept
    t_write(18'h00022, 16'h5678, 2'b11);
    t_write(18'h00022, 16'h9F00, 2'b10);
    t_read (18'h00022, 2'b11, 16'h9F78);          // R3 lower kept
    t_read (18'h00022, 2'b10, 16'h9F00);          // R4 upper lane only
    t_noop(1'b1, 18'h2A511);
    t_noop(1'b0, 18'h2A511);
    t_read (18'h2A511, 2'b11, 16'h12CD);          // R5 memory unchanged
    t_back_to_back();
    t_read (18'h01333, 2'b01, 16'h3333);
    chk(viol == 0, "R2 R6 R9 RAM model violations", viol, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

endmodule